// File: doc/BRIEF.md
# Wiper Position Register with One-Hot Tap Select

This block holds the position of a digital potentiometer wiper as a small volatile register. It turns that position into a one-hot enable vector, with one bit for each tap switch of a resistor ladder. The ladder itself sits outside the block; only the switch enables leave it. The current position is also presented as a plain value, so that a command front-end can read it back or copy it into one of the data registers.

The position can change in four ways. When reset is released it is recalled from data register slot 0. A parallel transfer copies any selected data register slot. A write stream delivers a new value from the serial command front-end. A step request moves the wiper by one tap up or down, and it stops at either end of the ladder.

The write stream uses a valid/ready handshake. A word is taken on a clock edge where both `wr_valid` and `wr_ready` are high. `wr_ready` drops while a recall is pending or a transfer is requested in the same cycle. The sender must then hold `wr_valid` and `wr_data` steady until it sees ready. Transfer and step requests are plain one-cycle strobes, and a step request that loses arbitration is dropped. Every applied load raises `load_done` for one cycle. That cycle is the first one in which the new position is visible.

Top module: `wiper_tap_ctrl`

## Requirements
- R1: While `rst_n` is low, `wiper_q` is 0, `tap_en` has only bit 0 set, `load_done` is 0 and `wr_ready` is 0.
- R2: `tap_en` always has exactly one bit set, at the index equal to `wiper_q`: position 0 enables bit 0 (low end) and position 63 enables bit 63 (high end).
- R3: On the first rising edge with `rst_n` high, `wiper_q` is loaded from data slot 0 (`dreg_bank[5:0]`).
- R4: With `xfer_req` high, the next edge loads `wiper_q` from slot `xfer_sel`, where slot k occupies `dreg_bank[6k+5:6k]`.
- R5: An edge where `wr_valid` and `wr_ready` are both high loads `wr_data` into `wiper_q`. `wr_ready` is low while a recall is pending or `xfer_req` is high.
- R6: A step request with `step_up` high raises `wiper_q` by one. With `step_up` low it lowers `wiper_q` by one.
- R7: A step up at 63 leaves 63, and a step down at 0 leaves 0. Neither wraps.
- R8: When loads coincide, the order is recall first, then transfer, then write, then step. A losing write stays pending, and a losing step is dropped.
- R9: `load_done` is high for exactly the one cycle after each applied load, saturated steps included. With no load, `load_done` is low and `wiper_q` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dreg_bank | input | 24 | Data register contents, slot k at bits 6k+5:6k |
| xfer_req | input | 1 | Parallel transfer strobe |
| xfer_sel | input | 2 | Slot chosen for transfer |
| wr_valid | input | 1 | Write word valid |
| wr_ready | output | 1 | Write word accepted on this edge if valid |
| wr_data | input | 6 | Write word |
| step_req | input | 1 | One-tap step strobe |
| step_up | input | 1 | Step direction, 1 = toward high end |
| wiper_q | output | 6 | Current wiper position |
| tap_en | output | 64 | One-hot tap switch enables |
| load_done | output | 1 | One-cycle pulse after each applied load |

## Verification
Every load request is sampled on a rising edge, and its result appears one edge later. At that point `wiper_q`, `tap_en` and `load_done` all show the new state together. The exception is `wr_ready`, which is combinational and valid in the same cycle as the requests it depends on. The bench drives inputs on falling edges, waits for one rising edge, and checks all outputs on the following falling edge. Ready is checked a moment after the drive, before the edge. Collisions are set up in a single cycle, so the winner and the fate of each loser are observed one edge later.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_RECALL,
    SRC_XFER,
    SRC_WRITE,
    SRC_STEP
  } load_src_e;

endpackage

// File: rtl/wiper_step.sv
module wiper_step #(
  parameter int WIDTH = 6
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             up,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] BOT = '0;
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    if (up) nxt = (cur == TOP) ? cur : cur + ONE;
    else    nxt = (cur == BOT) ? cur : cur - ONE;
  end
endmodule

// File: rtl/wiper_load_arb.sv
module wiper_load_arb
  import wiper_pkg::*;
#(
  parameter int WIDTH    = 6,
  parameter int NUM_DREG = 4,
  localparam int SEL_W   = $clog2(NUM_DREG)
) (
  input  logic                      recall_pend,
  input  logic [NUM_DREG*WIDTH-1:0] dreg_bank,
  input  logic                      xfer_req,
  input  logic [SEL_W-1:0]          xfer_sel,
  input  logic                      wr_valid,
  input  logic [WIDTH-1:0]          wr_data,
  input  logic                      step_req,
  input  logic [WIDTH-1:0]          step_val,
  output logic                      wr_ready,
  output load_src_e                 src,
  output logic [WIDTH-1:0]          next_val
);
  logic [WIDTH-1:0] slot [NUM_DREG];

  for (genvar k = 0; k < NUM_DREG; k++) begin : g_slot
    assign slot[k] = dreg_bank[k*WIDTH +: WIDTH];
  end

  assign wr_ready = !recall_pend && !xfer_req;

  always_comb begin
    src      = SRC_NONE;
    next_val = slot[0];
    if (recall_pend) begin
      src      = SRC_RECALL;
      next_val = slot[0];
    end else if (xfer_req) begin
      src      = SRC_XFER;
      next_val = slot[xfer_sel];
    end else if (wr_valid) begin
      src      = SRC_WRITE;
      next_val = wr_data;
    end else if (step_req) begin
      src      = SRC_STEP;
      next_val = step_val;
    end
  end
endmodule

// File: rtl/tap_onehot_decode.sv
module tap_onehot_decode #(
  parameter int WIDTH = 6,
  localparam int TAPS = 1 << WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pos,
  output logic [TAPS-1:0]  tap_en
);
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    localparam logic [WIDTH-1:0] IDX = WIDTH'(i);
    assign tap_en[i] = (pos == IDX);
  end

  // R2: one switch on at a time
  a_r2_single_tap: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_en) == 1);
endmodule

// File: rtl/wiper_tap_ctrl.sv
module wiper_tap_ctrl
  import wiper_pkg::*;
#(
  parameter int WIDTH    = 6,
  parameter int NUM_DREG = 4,
  localparam int SEL_W   = $clog2(NUM_DREG),
  localparam int TAPS    = 1 << WIDTH
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_DREG*WIDTH-1:0] dreg_bank,
  input  logic                      xfer_req,
  input  logic [SEL_W-1:0]          xfer_sel,
  input  logic                      wr_valid,
  output logic                      wr_ready,
  input  logic [WIDTH-1:0]          wr_data,
  input  logic                      step_req,
  input  logic                      step_up,
  output logic [WIDTH-1:0]          wiper_q,
  output logic [TAPS-1:0]           tap_en,
  output logic                      load_done
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  logic             recall_pend;
  logic [WIDTH-1:0] step_val;
  logic [WIDTH-1:0] next_val;
  load_src_e        src;

  wiper_step #(.WIDTH(WIDTH)) u_step (
    .cur (wiper_q),
    .up  (step_up),
    .nxt (step_val)
  );

  wiper_load_arb #(.WIDTH(WIDTH), .NUM_DREG(NUM_DREG)) u_arb (
    .recall_pend (recall_pend),
    .dreg_bank   (dreg_bank),
    .xfer_req    (xfer_req),
    .xfer_sel    (xfer_sel),
    .wr_valid    (wr_valid),
    .wr_data     (wr_data),
    .step_req    (step_req),
    .step_val    (step_val),
    .wr_ready    (wr_ready),
    .src         (src),
    .next_val    (next_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wiper_q     <= '0;
      recall_pend <= 1'b1;
      load_done   <= 1'b0;
    end else begin
      recall_pend <= 1'b0;
      load_done   <= (src != SRC_NONE);
      if (src != SRC_NONE) wiper_q <= next_val;
    end
  end

  tap_onehot_decode #(.WIDTH(WIDTH)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .pos    (wiper_q),
    .tap_en (tap_en)
  );

  logic [WIDTH-1:0] chosen_slot;
  assign chosen_slot = dreg_bank[xfer_sel*WIDTH +: WIDTH];

  // R3: recall comes from slot 0
  a_r3_recall_slot0: assert property (@(posedge clk) disable iff (!rst_n)
    recall_pend |=> wiper_q == $past(dreg_bank[WIDTH-1:0]));
  // R4: transfer copies the chosen slot
  a_r4_xfer_value: assert property (@(posedge clk) disable iff (!rst_n)
    (!recall_pend && xfer_req) |=> wiper_q == $past(chosen_slot));
  // R5 / R8: accepted write beats a simultaneous step
  a_r5_write_value: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> wiper_q == $past(wr_data));
  // R7: no wrap at either end
  a_r7_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_STEP && step_up && wiper_q == TOP) |=> wiper_q == TOP);
  a_r7_no_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_STEP && !step_up && wiper_q == '0) |=> wiper_q == '0);
  // R9: done pulse tracks applied loads, idle holds
  a_r9_done_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
    (src != SRC_NONE) |=> load_done);
  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_NONE) |=> (!load_done && $stable(wiper_q)));
endmodule

// File: tb/sim_wiper_tap_ctrl.sv
module sim_wiper_tap_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] dreg_bank;
  logic        xfer_req;
  logic [1:0]  xfer_sel;
  logic        wr_valid;
  logic        wr_ready;
  logic [5:0]  wr_data;
  logic        step_req;
  logic        step_up;
  logic [5:0]  wiper_q;
  logic [63:0] tap_en;
  logic        load_done;

  int checks   = 0;
  int failures = 0;
  bit ended    = 0;

  always #4 clk = ~clk;

  wiper_tap_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .dreg_bank(dreg_bank),
    .xfer_req(xfer_req), .xfer_sel(xfer_sel),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .step_req(step_req), .step_up(step_up),
    .wiper_q(wiper_q), .tap_en(tap_en), .load_done(load_done)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(string req, logic [5:0] pos, logic done);
    chk(req, 64'(wiper_q), 64'(pos));
    chk({req, " done"}, 64'(load_done), 64'(done));
    chk("R2 tap", tap_en, 64'd1 << pos);
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic do_write(logic [5:0] v);
    wr_valid = 1; wr_data = v;
    cycle();
    wr_valid = 0;
  endtask

  task automatic test_reset_recall();
    rst_n = 0; xfer_req = 0; xfer_sel = 0; wr_valid = 0; wr_data = 0;
    step_req = 0; step_up = 0;
    dreg_bank = {6'h3C, 6'h33, 6'h07, 6'h15};
    cycle(); cycle();
    chk_state("R1 reset", 6'h00, 1'b0);
    chk("R1 ready", 64'(wr_ready), 64'd0);
    // release with a transfer competing: recall must win (R8)
    rst_n = 1; xfer_req = 1; xfer_sel = 3;
    cycle();
    xfer_req = 0;
    chk_state("R3 R8 recall", 6'h15, 1'b1);
    cycle();
    chk_state("R9 idle hold", 6'h15, 1'b0);
  endtask

  task automatic test_xfer();
    xfer_req = 1; xfer_sel = 3;
    cycle();
    chk_state("R4 slot3", 6'h3C, 1'b1);
    xfer_sel = 1;
    cycle();
    xfer_req = 0;
    chk_state("R4 slot1", 6'h07, 1'b1);
  endtask

  task automatic test_write_backpressure();
    wr_valid = 1; wr_data = 6'h11; xfer_req = 1; xfer_sel = 2;
    #1;
    chk("R5 ready low", 64'(wr_ready), 64'd0);
    @(posedge clk); @(negedge clk);
    xfer_req = 0;
    chk_state("R8 xfer over write", 6'h33, 1'b1);
    #1;
    chk("R5 ready high", 64'(wr_ready), 64'd1);
    @(posedge clk); @(negedge clk);
    wr_valid = 0;
    chk_state("R5 held write taken", 6'h11, 1'b1);
  endtask

  task automatic test_step();
    wr_valid = 1; wr_data = 6'h20; step_req = 1; step_up = 1;
    cycle();
    wr_valid = 0;
    chk_state("R8 write over step", 6'h20, 1'b1);
    cycle();
    chk_state("R6 up", 6'h21, 1'b1);
    step_up = 0;
    cycle();
    step_req = 0;
    chk_state("R6 down", 6'h20, 1'b1);
  endtask

  task automatic test_saturate();
    do_write(6'h3F);
    chk_state("R2 high end", 6'h3F, 1'b1);
    step_req = 1; step_up = 1;
    cycle();
    step_req = 0;
    chk_state("R7 top", 6'h3F, 1'b1);
    do_write(6'h00);
    chk_state("R2 low end", 6'h00, 1'b1);
    step_req = 1; step_up = 0;
    cycle();
    step_req = 0;
    chk_state("R7 bottom", 6'h00, 1'b1);
    cycle();
    chk_state("R9 no load", 6'h00, 1'b0);
  endtask

  initial begin
    test_reset_recall();
    test_xfer();
    test_write_backpressure();
    test_step();
    test_saturate();
    finish_run();
  end

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule